// File: doc/BRIEF.md
# Single-Precision Special-Operand Resolver

This block sits beside the datapath of a binary single-precision arithmetic unit. It decodes each 32-bit operand into one of six classes: zero, subnormal, normal, infinity, quiet NaN and signaling NaN. From those classes and the selected operation it decides whether the result has to be a NaN, which NaN word to return, whether the invalid-operation exception applies, and whether a trap must be requested. The datapath then only has to multiplex the NaN word over its own result when `res_is_nan` is high.

NaN propagation follows a fixed priority. A signaling operand always wins, with operand A ahead of operand B. Between two quiet NaNs, the one whose fraction is numerically smaller is returned. A lone NaN is returned as it is. When no operand is a NaN but the operation has no defined value (opposite infinities meeting in an addition, equal infinities meeting in a subtraction, or zero times infinity), a fixed default quiet NaN is generated. When traps are disabled, a signaling NaN is quieted on its way to the result. When traps are enabled, it passes through unchanged and a trap request is raised.

The logic is purely combinational. A parameter adds one register stage at the outputs.

Top module: `fp_special_resolve`

## Requirements
- R1: `class_a` and `class_b` each carry exactly one set bit after reset, using this map: bit 0 zero, bit 1 subnormal, bit 2 normal, bit 3 infinity, bit 4 quiet NaN, bit 5 signaling NaN.
- R2: An operand is classed as follows. An exponent field (bits 30:23) of 0 with a zero fraction (bits 22:0) is zero, whatever the sign. An exponent field of 0 with a nonzero fraction is subnormal. An exponent field from 1 to 254 is normal.
- R3: An exponent field of 255 with a zero fraction is infinity. An exponent field of 255 with a nonzero fraction is a NaN, which is quiet when fraction bit 22 is 1 and signaling when it is 0.
- R4: If either operand is a signaling NaN, `invalid_flag` is 1 and the returned NaN is taken from operand A if A is signaling, otherwise from operand B.
- R5: With `invalid_trap_en` at 0, a returned signaling NaN has bit 22 set, and its sign and all other bits are kept. Every NaN word returned in this mode has exponent 255 and bit 22 set.
- R6: With `invalid_trap_en` at 1, a returned signaling NaN is passed unchanged. `trap_req` always equals `invalid_flag` AND `invalid_trap_en`.
- R7: If quiet NaNs are present and no signaling NaN, `invalid_flag` is 0. When only one operand is a NaN, that word is returned unchanged.
- R8: If both operands are quiet NaNs, the word whose 23-bit fraction is smaller as an unsigned number is returned. On equal fractions, operand A is returned.
- R9: `op_sel` selects the operation: 00 add, 01 subtract, 10 multiply, 11 none. With no NaN operand, each of the following gives `res_is_nan`=1, `nan_word`=0x7FC00000 and `invalid_flag`=1: add of infinities with different signs; subtract of infinities with equal signs; multiply of zero by infinity in either order. Code 11 never raises the invalid flag from non-NaN operands.
- R10: When neither a NaN operand nor an invalid operation is present, `res_is_nan`, `nan_word`, `invalid_flag` and `trap_req` are all 0.
- R11: With `REG_OUT`=1, every output shows the result for the inputs sampled at the previous rising clock edge, and all outputs are 0 while `rst_n` is low. With `REG_OUT`=0, the outputs follow the inputs combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| op_sel | input | 2 | Operation code: 00 add, 01 subtract, 10 multiply, 11 none |
| invalid_trap_en | input | 1 | 1 to trap on invalid operation instead of quieting |
| class_a | output | 6 | One-hot class of operand A |
| class_b | output | 6 | One-hot class of operand B |
| res_is_nan | output | 1 | Result must be the NaN word |
| nan_word | output | 32 | NaN to return; 0 when `res_is_nan` is 0 |
| invalid_flag | output | 1 | Invalid-operation exception |
| trap_req | output | 1 | Invalid trap requested |

## Verification
The bench builds two copies with the default 8-bit exponent and 23-bit fraction. One copy has `REG_OUT`=1 and the other has `REG_OUT`=0, and both receive the same stimulus. The registered copy makes the reset values and the one-cycle output delay observable. Checking the registered copy one cycle after the combinational copy shows whether the optional register changes any value. The default widths put the quiet bit at position 22 and the default NaN at 0x7FC00000, so the hand-computed words in the bench apply directly.

// File: rtl/fpsr_pkg.sv
package fpsr_pkg;
  localparam int CLS_W    = 6;
  localparam int CLS_ZERO = 0;
  localparam int CLS_SUB  = 1;
  localparam int CLS_NORM = 2;
  localparam int CLS_INF  = 3;
  localparam int CLS_QNAN = 4;
  localparam int CLS_SNAN = 5;

  typedef enum logic [1:0] {
    OP_ADD  = 2'b00,
    OP_SUB  = 2'b01,
    OP_MUL  = 2'b10,
    OP_NONE = 2'b11
  } fpsr_op_e;
endpackage

// File: rtl/fpsr_classify.sv
module fpsr_classify
  import fpsr_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int W     = 1 + EXP_W + FRAC_W
) (
  input  logic [W-1:0]      word,
  output logic [CLS_W-1:0]  cls,
  output logic              sign,
  output logic [FRAC_W-1:0] frac
);
  function automatic logic [CLS_W-1:0] decode_class(
    input logic [EXP_W-1:0]  e,
    input logic [FRAC_W-1:0] f
  );
    logic [CLS_W-1:0] c;
    c = '0;
    if (e == '0) begin
      if (f == '0) c[CLS_ZERO] = 1'b1;
      else         c[CLS_SUB]  = 1'b1;
    end else if (e == '1) begin
      if (f == '0)           c[CLS_INF]  = 1'b1;
      else if (f[FRAC_W-1])  c[CLS_QNAN] = 1'b1;
      else                   c[CLS_SNAN] = 1'b1;
    end else begin
      c[CLS_NORM] = 1'b1;
    end
    return c;
  endfunction

  assign sign = word[W-1];
  assign frac = word[FRAC_W-1:0];
  assign cls  = decode_class(word[W-2:FRAC_W], word[FRAC_W-1:0]);
endmodule

// File: rtl/fpsr_nan_pick.sv
module fpsr_nan_pick
  import fpsr_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int W     = 1 + EXP_W + FRAC_W
) (
  input  logic [W-1:0]     word_a,
  input  logic [W-1:0]     word_b,
  input  logic [CLS_W-1:0] cls_a,
  input  logic [CLS_W-1:0] cls_b,
  input  logic             trap_en,
  output logic [W-1:0]     pick,
  output logic             snan_any,
  output logic             nan_any
);
  function automatic logic [W-1:0] make_quiet(input logic [W-1:0] w);
    logic [W-1:0] q;
    q = w;
    q[FRAC_W-1] = 1'b1;
    return q;
  endfunction

  function automatic logic b_smaller(input logic [W-1:0] a, input logic [W-1:0] b);
    return b[FRAC_W-1:0] < a[FRAC_W-1:0];
  endfunction

  logic         nan_a, nan_b;
  logic [W-1:0] sel;

  assign nan_a    = cls_a[CLS_QNAN] | cls_a[CLS_SNAN];
  assign nan_b    = cls_b[CLS_QNAN] | cls_b[CLS_SNAN];
  assign snan_any = cls_a[CLS_SNAN] | cls_b[CLS_SNAN];
  assign nan_any  = nan_a | nan_b;

  always_comb begin
    if (cls_a[CLS_SNAN])        sel = word_a;
    else if (cls_b[CLS_SNAN])   sel = word_b;
    else if (nan_a && nan_b)    sel = b_smaller(word_a, word_b) ? word_b : word_a;
    else if (nan_b)             sel = word_b;
    else                        sel = word_a;
  end

  assign pick = trap_en ? sel : make_quiet(sel);
endmodule

// File: rtl/fpsr_invalid_op.sv
module fpsr_invalid_op
  import fpsr_pkg::*;
(
  input  logic [CLS_W-1:0] cls_a,
  input  logic [CLS_W-1:0] cls_b,
  input  logic             sign_a,
  input  logic             sign_b,
  input  fpsr_op_e         op,
  output logic             op_invalid
);
  logic both_inf, zero_by_inf;

  assign both_inf    = cls_a[CLS_INF] & cls_b[CLS_INF];
  assign zero_by_inf = (cls_a[CLS_ZERO] & cls_b[CLS_INF]) |
                       (cls_a[CLS_INF]  & cls_b[CLS_ZERO]);

  always_comb begin
    unique case (op)
      OP_ADD:  op_invalid = both_inf & (sign_a ^ sign_b);
      OP_SUB:  op_invalid = both_inf & ~(sign_a ^ sign_b);
      OP_MUL:  op_invalid = zero_by_inf;
      default: op_invalid = 1'b0;
    endcase
  end
endmodule

// File: rtl/fp_special_resolve.sv
module fp_special_resolve
  import fpsr_pkg::*;
#(
  parameter int EXP_W   = 8,
  parameter int FRAC_W  = 23,
  parameter bit REG_OUT = 1'b1,
  localparam int W      = 1 + EXP_W + FRAC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [W-1:0]     op_a,
  input  logic [W-1:0]     op_b,
  input  logic [1:0]       op_sel,
  input  logic             invalid_trap_en,
  output logic [CLS_W-1:0] class_a,
  output logic [CLS_W-1:0] class_b,
  output logic             res_is_nan,
  output logic [W-1:0]     nan_word,
  output logic             invalid_flag,
  output logic             trap_req
);
  localparam logic [W-1:0] DEF_QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
  localparam int BUNDLE_W = 2*CLS_W + W + 3;

  logic [CLS_W-1:0]  cls_a_w, cls_b_w;
  logic              sgn_a, sgn_b;
  logic [FRAC_W-1:0] frac_a, frac_b;
  logic [W-1:0]      pick_w, nan_w;
  logic              snan_any, nan_any, op_inv;
  logic              inv_w, trap_w, res_nan_w;

  fpsr_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls_a (
    .word(op_a), .cls(cls_a_w), .sign(sgn_a), .frac(frac_a));
  fpsr_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls_b (
    .word(op_b), .cls(cls_b_w), .sign(sgn_b), .frac(frac_b));

  fpsr_nan_pick #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_pick (
    .word_a(op_a), .word_b(op_b), .cls_a(cls_a_w), .cls_b(cls_b_w),
    .trap_en(invalid_trap_en), .pick(pick_w), .snan_any(snan_any), .nan_any(nan_any));

  fpsr_invalid_op u_inv (
    .cls_a(cls_a_w), .cls_b(cls_b_w), .sign_a(sgn_a), .sign_b(sgn_b),
    .op(fpsr_op_e'(op_sel)), .op_invalid(op_inv));

  // NaN propagation outranks a generated default NaN
  assign res_nan_w = nan_any | op_inv;
  assign inv_w     = snan_any | op_inv;
  assign trap_w    = inv_w & invalid_trap_en;
  assign nan_w     = !res_nan_w ? '0 : (nan_any ? pick_w : DEF_QNAN);

  logic [BUNDLE_W-1:0] bundle_d, bundle_q;
  assign bundle_d = {cls_a_w, cls_b_w, res_nan_w, nan_w, inv_w, trap_w};

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bundle_q <= '0;
        else        bundle_q <= bundle_d;
      end
    end else begin : g_comb
      assign bundle_q = bundle_d;
    end
  endgenerate

  assign {class_a, class_b, res_is_nan, nan_word, invalid_flag, trap_req} = bundle_q;
endmodule

// File: rtl/fpsr_checker.sv
module fpsr_checker
  import fpsr_pkg::*;
#(
  parameter int EXP_W   = 8,
  parameter int FRAC_W  = 23,
  parameter bit REG_OUT = 1'b1,
  localparam int W      = 1 + EXP_W + FRAC_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             trap_en,
  input logic [CLS_W-1:0] cls_a_w,
  input logic [CLS_W-1:0] cls_b_w,
  input logic             inv_w,
  input logic             trap_w,
  input logic             res_nan_w,
  input logic [W-1:0]     nan_w,
  input logic             invalid_flag,
  input logic             trap_req
);
  logic q_only;
  assign q_only = (cls_a_w[CLS_QNAN] | cls_b_w[CLS_QNAN]) &
                  ~(cls_a_w[CLS_SNAN] | cls_b_w[CLS_SNAN]);

  p_onehot_a_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(cls_a_w) == 1);
  p_onehot_b_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(cls_b_w) == 1);
  p_snan_invalid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cls_a_w[CLS_SNAN] | cls_b_w[CLS_SNAN]) |-> inv_w);
  p_quiet_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (res_nan_w && !trap_en) |-> (nan_w[FRAC_W-1] && (&nan_w[W-2:FRAC_W])));
  p_trap_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    trap_w |-> (inv_w && trap_en));
  p_qnan_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
    q_only |-> !inv_w);
  p_clean_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !res_nan_w |-> (nan_w == '0 && !inv_w && !trap_w));

  generate
    if (REG_OUT) begin : g_lat
      p_latency_r11: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (invalid_flag == $past(inv_w) && trap_req == $past(trap_w)));
    end
  endgenerate
endmodule

bind fp_special_resolve fpsr_checker #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .REG_OUT(REG_OUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .trap_en(invalid_trap_en),
  .cls_a_w(cls_a_w), .cls_b_w(cls_b_w), .inv_w(inv_w), .trap_w(trap_w),
  .res_nan_w(res_nan_w), .nan_w(nan_w),
  .invalid_flag(invalid_flag), .trap_req(trap_req));

// File: tb/tb_fp_special_resolve.sv
module tb_fp_special_resolve;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] op_a = '0, op_b = '0;
  logic [1:0]  op_sel = 2'b00;
  logic        trap_en = 1'b0;

  logic [5:0]  ca_r, cb_r, ca_c, cb_c;
  logic        nan_r, inv_r, trp_r, nan_c, inv_c, trp_c;
  logic [31:0] w_r, w_c;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  fp_special_resolve #(.REG_OUT(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .op_sel(op_sel),
    .invalid_trap_en(trap_en), .class_a(ca_r), .class_b(cb_r),
    .res_is_nan(nan_r), .nan_word(w_r), .invalid_flag(inv_r), .trap_req(trp_r));

  fp_special_resolve #(.REG_OUT(1'b0)) dut_c (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .op_sel(op_sel),
    .invalid_trap_en(trap_en), .class_a(ca_c), .class_b(cb_c),
    .res_is_nan(nan_c), .nan_word(w_c), .invalid_flag(inv_c), .trap_req(trp_c));

  task automatic chk(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  // Drive at the falling edge, let the register load at the rising edge, sample at the next falling edge.
  task automatic run(input string tag, input logic [31:0] a, input logic [31:0] b,
                     input logic [1:0] op, input logic te,
                     input logic [5:0] eca, input logic [5:0] ecb, input logic enan,
                     input logic [31:0] ew, input logic einv, input logic etrp);
    @(negedge clk);
    op_a = a; op_b = b; op_sel = op; trap_en = te;
    @(posedge clk);
    @(negedge clk);
    chk(tag, "class_a",  {26'd0, ca_r}, {26'd0, eca});
    chk(tag, "class_b",  {26'd0, cb_r}, {26'd0, ecb});
    chk(tag, "is_nan",   {31'd0, nan_r}, {31'd0, enan});
    chk(tag, "word",     w_r, ew);
    chk(tag, "invalid",  {31'd0, inv_r}, {31'd0, einv});
    chk(tag, "trap",     {31'd0, trp_r}, {31'd0, etrp});
    chk(tag, "comb_word", w_c, ew);
    chk(tag, "comb_inv", {29'd0, inv_c, trp_c, nan_c}, {29'd0, einv, etrp, enan});
    chk(tag, "comb_cls", {20'd0, ca_c, cb_c}, {20'd0, eca, ecb});
  endtask

  localparam logic [5:0] C_Z = 6'b000001, C_D = 6'b000010, C_N = 6'b000100,
                         C_I = 6'b001000, C_Q = 6'b010000, C_S = 6'b100000;

  task automatic t_reset();
    op_a = 32'h7F800001; op_b = 32'h7FC00000; trap_en = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R11", "reset cls", {20'd0, ca_r, cb_r}, 32'd0);
    chk("R11", "reset flags", {29'd0, nan_r, inv_r, trp_r}, 32'd0);
    chk("R11", "reset word", w_r, 32'd0);
    rst_n = 1'b1;
  endtask

  task automatic t_classes();
    run("R2", 32'h00000000, 32'h00000001, 2'b00, 1'b0, C_Z, C_D, 1'b0, 32'h0, 1'b0, 1'b0);
    run("R2", 32'h80000000, 32'h807FFFFF, 2'b10, 1'b0, C_Z, C_D, 1'b0, 32'h0, 1'b0, 1'b0);
    run("R1", 32'h3F800000, 32'h7F7FFFFF, 2'b01, 1'b0, C_N, C_N, 1'b0, 32'h0, 1'b0, 1'b0);
    run("R3", 32'h7F800000, 32'hC0000000, 2'b00, 1'b1, C_I, C_N, 1'b0, 32'h0, 1'b0, 1'b0);
    run("R10", 32'h00800000, 32'hFF800000, 2'b10, 1'b1, C_N, C_I, 1'b0, 32'h0, 1'b0, 1'b0);
  endtask

  task automatic t_signaling();
    run("R4", 32'h7F800001, 32'h3F800000, 2'b00, 1'b0, C_S, C_N, 1'b1, 32'h7FC00001, 1'b1, 1'b0);
    run("R5", 32'hFFA00005, 32'h00000000, 2'b10, 1'b0, C_S, C_Z, 1'b1, 32'hFFE00005, 1'b1, 1'b0);
    run("R4", 32'h7FC00001, 32'hFF800003, 2'b01, 1'b0, C_Q, C_S, 1'b1, 32'hFFC00003, 1'b1, 1'b0);
    run("R4", 32'h7F800009, 32'h7F800002, 2'b00, 1'b0, C_S, C_S, 1'b1, 32'h7FC00009, 1'b1, 1'b0);
    run("R6", 32'h7F800001, 32'h3F800000, 2'b00, 1'b1, C_S, C_N, 1'b1, 32'h7F800001, 1'b1, 1'b1);
  endtask

  task automatic t_quiet();
    run("R7", 32'h7FC00010, 32'h40A00000, 2'b00, 1'b0, C_Q, C_N, 1'b1, 32'h7FC00010, 1'b0, 1'b0);
    run("R7", 32'h3F800000, 32'hFFFFFFFF, 2'b10, 1'b1, C_N, C_Q, 1'b1, 32'hFFFFFFFF, 1'b0, 1'b0);
    run("R8", 32'h7FC00010, 32'hFFC00002, 2'b00, 1'b0, C_Q, C_Q, 1'b1, 32'hFFC00002, 1'b0, 1'b0);
    run("R8", 32'h7FC00002, 32'hFFC00010, 2'b01, 1'b0, C_Q, C_Q, 1'b1, 32'h7FC00002, 1'b0, 1'b0);
    run("R8", 32'h7FC00005, 32'hFFC00005, 2'b10, 1'b0, C_Q, C_Q, 1'b1, 32'h7FC00005, 1'b0, 1'b0);
  endtask

  task automatic t_invalid_ops();
    run("R9", 32'h7F800000, 32'hFF800000, 2'b00, 1'b0, C_I, C_I, 1'b1, 32'h7FC00000, 1'b1, 1'b0);
    run("R9", 32'h7F800000, 32'h7F800000, 2'b00, 1'b0, C_I, C_I, 1'b0, 32'h0, 1'b0, 1'b0);
    run("R9", 32'hFF800000, 32'hFF800000, 2'b01, 1'b0, C_I, C_I, 1'b1, 32'h7FC00000, 1'b1, 1'b0);
    run("R9", 32'h7F800000, 32'hFF800000, 2'b01, 1'b0, C_I, C_I, 1'b0, 32'h0, 1'b0, 1'b0);
    run("R9", 32'h80000000, 32'h7F800000, 2'b10, 1'b0, C_Z, C_I, 1'b1, 32'h7FC00000, 1'b1, 1'b0);
    run("R9", 32'hFF800000, 32'h00000000, 2'b10, 1'b0, C_I, C_Z, 1'b1, 32'h7FC00000, 1'b1, 1'b0);
    run("R9", 32'h00000001, 32'h7F800000, 2'b10, 1'b0, C_D, C_I, 1'b0, 32'h0, 1'b0, 1'b0);
    run("R9", 32'h7F800000, 32'hFF800000, 2'b11, 1'b0, C_I, C_I, 1'b0, 32'h0, 1'b0, 1'b0);
    run("R6", 32'h00000000, 32'h7F800000, 2'b10, 1'b1, C_Z, C_I, 1'b1, 32'h7FC00000, 1'b1, 1'b1);
    run("R7", 32'h7FC00004, 32'h7F800000, 2'b10, 1'b1, C_Q, C_I, 1'b1, 32'h7FC00004, 1'b0, 1'b0);
  endtask

  task automatic t_latency();
    @(negedge clk);
    op_a = 32'h7F800001; op_b = 32'h0; op_sel = 2'b00; trap_en = 1'b1;
    #1;
    chk("R11", "comb now", {30'd0, inv_c, trp_c}, 32'd3);
    chk("R11", "reg holds", {30'd0, inv_r, trp_r}, 32'd0);
    @(posedge clk);
    #1;
    chk("R11", "reg after edge", {30'd0, inv_r, trp_r}, 32'd3);
    chk("R11", "reg word", w_r, 32'h7F800001);
  endtask

  initial begin
    t_reset();
    t_classes();
    t_signaling();
    t_quiet();
    t_invalid_ops();
    run("R10", 32'h3F800000, 32'h3F800000, 2'b00, 1'b0, C_N, C_N, 1'b0, 32'h0, 1'b0, 1'b0);
    t_latency();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule